// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Framing

This block turns a byte written into a write-only holding register into an asynchronous serial frame on a single output line. The caller presents a byte with a one-cycle write strobe. As soon as the internal shifter is idle, the byte moves from the holding register into the shifter. The empty flag rises at that same moment, so the next byte can be written while the current frame is still on the line.

The frame format comes from a small set of line-control inputs:

- the data length, five to eight bits;
- the stop-bit mode;
- a parity enable;
- an even/odd parity select.

The bit rate comes from a 16-bit divisor, presented as separate low and high bytes. The divisor produces a tick at sixteen times the bit rate. The framing inputs are sampled when a frame starts and are held for that whole frame.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever the shifter is idle, `txd` is 1 and `thr_empty` is 1. Asserting `rst_n` low in the middle of a frame returns `txd` to 1 at once and discards the frame.
- R2: A cycle with `wr_stb` high makes `thr_empty` 0 from the next cycle. If the shifter is idle, the byte moves to the shifter on the following edge and `thr_empty` returns to 1 at the start of the frame.
- R3: The divisor is `{div_hi, div_lo}`, and a value of 0 acts as 1. Every 16-tick bit lasts exactly 16 × divisor clock cycles, counted from the edge that starts the frame.
- R4: A frame is a low start bit, then the data bits LSB first. The number of data bits is set by `lcr_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R5: When `lcr_par_en` is 1, one parity bit follows the last data bit. With `lcr_par_even` = 1 the number of ones across the data bits and the parity bit is even; with 0 it is odd. When `lcr_par_en` is 0, no parity bit is sent.
- R6: The stop interval is high and has one of three lengths:
  - 16 ticks when `lcr_stop` is 0;
  - 24 ticks when `lcr_stop` is 1 and `lcr_len` is 00;
  - 32 ticks when `lcr_stop` is 1 and `lcr_len` is 01, 10 or 11.
- R7: All line-control inputs are captured at frame start. Changing them during a frame has no effect on that frame.
- R8: A write while the holding register is already full replaces the pending byte, so the most recently written byte is the one sent next.
- R9: If a byte is pending when a stop interval ends, the line is high for exactly one clock cycle. The next start bit then begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo | input | 8 | Low byte of the bit-rate divisor |
| div_hi | input | 8 | High byte of the bit-rate divisor |
| lcr_len | input | 2 | Data length code (00 = 5 bits through 11 = 8 bits) |
| lcr_stop | input | 1 | Stop mode: 0 gives one stop bit, 1 gives a long stop interval |
| lcr_par_en | input | 1 | Parity bit enable |
| lcr_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| wr_data | input | 8 | Byte to load into the holding register |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| txd | output | 1 | Serial line output; high when idle |
| thr_empty | output | 1 | High when the holding register can take a new byte |

## Verification
The checker watches the following on every cycle:

- the line level in the idle, start and stop phases;
- that a transfer into the shifter happens only from a full holding register and always leads into a start bit;
- how `thr_empty` follows writes and transfers.

The other behaviours can only be shown by the bench decoding whole frames at the pins. These are the data order and length, the parity value, the exact stop length, the bit period for each divisor, the one-cycle gap between back-to-back frames, and the effects of overwrites, mid-frame control changes and mid-frame reset.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       long_stop;
    logic       par_on;
    logic       par_even;
  } frame_cfg_t;

  // number of data bits carried for a length code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // length of the stop interval in ticks, given the ticks per bit
  function automatic logic [7:0] stop_ticks(input frame_cfg_t f, input logic [7:0] ovs);
    if (!f.long_stop)
      return ovs;
    else if (f.len_code == 2'b00)
      return ovs + (ovs >> 1);
    else
      return ovs << 1;
  endfunction

  // parity bit over the data bits actually sent
  function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic [1:0] code,
                                   input logic even);
    logic [BYTE_W-1:0] mask;
    mask = 8'hFF >> (2'd3 - code);
    return (^(d & mask)) ^ ~even;
  endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick  = (cnt >= limit - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr || tick)
      cnt <= '0;
    else
      cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] data_q,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      full <= 1'b0;
    else if (wr_stb)
      full <= 1'b1;
    else if (take)
      full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (wr_stb)
      data_q <= wr_data;
  end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_data,
  input  frame_cfg_t        cfg_in,
  output logic              load,
  output logic              bit_done,
  output logic              txd,
  output logic              in_idle,
  output logic              in_start,
  output logic              in_stop
);
  localparam logic [7:0] OVS = 8'(OVERSAMPLE);

  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic [BYTE_W-1:0] shreg;
  logic              par_q;
  logic [7:0]        tick_cnt;
  logic [2:0]        bit_idx;
  logic [7:0]        end_ticks;
  logic              last_data;

  assign load      = (state == ST_IDLE) && hold_full;
  assign end_ticks = (state == ST_STOP) ? stop_ticks(cfg_q, OVS) : OVS;
  assign bit_done  = tick && (tick_cnt == end_ticks - 8'd1);
  assign last_data = ({1'b0, bit_idx} == data_bits(cfg_q.len_code) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_q    <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (state == ST_IDLE) begin
      if (load) begin
        cfg_q    <= cfg_in;
        shreg    <= hold_data;
        par_q    <= par_bit(hold_data, cfg_in.len_code, cfg_in.par_even);
        tick_cnt <= '0;
        bit_idx  <= '0;
        state    <= ST_START;
      end
    end else if (tick) begin
      if (bit_done) begin
        tick_cnt <= '0;
        unique case (state)
          ST_START: begin
            bit_idx <= '0;
            state   <= ST_DATA;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (last_data)
              state <= cfg_q.par_on ? ST_PAR : ST_STOP;
            else
              bit_idx <= bit_idx + 3'd1;
          end
          ST_PAR:  state <= ST_STOP;
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end else begin
        tick_cnt <= tick_cnt + 8'd1;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign in_idle  = (state == ST_IDLE);
  assign in_start = (state == ST_START);
  assign in_stop  = (state == ST_STOP);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import utx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] div_lo,
  input  logic [7:0] div_hi,
  input  logic [1:0] lcr_len,
  input  logic       lcr_stop,
  input  logic       lcr_par_en,
  input  logic       lcr_par_even,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  output logic       txd,
  output logic       thr_empty
);
  logic [DIV_W-1:0]  divisor;
  frame_cfg_t        cfg_now;
  logic              bit_tick;
  logic              frame_load;
  logic              bit_done;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              in_idle;
  logic              in_start;
  logic              in_stop;

  assign divisor = DIV_W'({div_hi, div_lo});
  assign cfg_now = '{len_code: lcr_len, long_stop: lcr_stop,
                     par_on: lcr_par_en, par_even: lcr_par_even};

  utx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .clr(frame_load), .divisor(divisor), .tick(bit_tick)
  );

  utx_hold #(.W(BYTE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(frame_load), .data_q(hold_data), .full(hold_full)
  );

  utx_shift #(.OVERSAMPLE(OVERSAMPLE)) shift_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .hold_full(hold_full),
    .hold_data(hold_data), .cfg_in(cfg_now), .load(frame_load),
    .bit_done(bit_done), .txd(txd), .in_idle(in_idle), .in_start(in_start),
    .in_stop(in_stop)
  );

  assign thr_empty = ~hold_full;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic thr_empty,
  input logic wr_stb,
  input logic frame_load,
  input logic bit_done,
  input logic in_idle,
  input logic in_start,
  input logic in_stop
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> txd);

  assert_load_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> !thr_empty);

  assert_empty_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && !wr_stb) |=> thr_empty);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !thr_empty);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_start |-> !txd);

  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> txd);

  assert_load_to_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> in_start);

  assert_stop_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && bit_done) |=> in_idle);
endmodule

bind uart_frame_tx utx_checker chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .thr_empty(thr_empty), .wr_stb(wr_stb),
  .frame_load(frame_load), .bit_done(bit_done), .in_idle(in_idle),
  .in_start(in_start), .in_stop(in_stop)
);

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_lo = 8'd1, div_hi = 8'd0;
  logic [1:0] lcr_len = 2'b11;
  logic       lcr_stop = 1'b0, lcr_par_en = 1'b0, lcr_par_even = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_stb = 1'b0;
  wire        txd;
  wire        thr_empty;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
    .lcr_len(lcr_len), .lcr_stop(lcr_stop), .lcr_par_en(lcr_par_en),
    .lcr_par_even(lcr_par_even), .wr_data(wr_data), .wr_stb(wr_stb),
    .txd(txd), .thr_empty(thr_empty)
  );

  // {data, len, stop, par_en, par_even, divisor}
  localparam logic [28:0] VEC [6] = '{
    {8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 16'd1},
    {8'h3C, 2'b00, 1'b1, 1'b1, 1'b1, 16'd2},
    {8'h5B, 2'b01, 1'b1, 1'b1, 1'b0, 16'd3},
    {8'h7E, 2'b10, 1'b0, 1'b1, 1'b1, 16'd0},
    {8'hC3, 2'b11, 1'b1, 1'b0, 1'b0, 16'd2},
    {8'h96, 2'b00, 1'b0, 1'b0, 1'b0, 16'd256}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_data = b;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  function automatic int eff_div(input logic [15:0] d);
    return (d == 16'd0) ? 1 : int'(d);
  endfunction

  function automatic int stop_len(input logic [1:0] l, input logic s);
    if (!s) return 16;
    if (l == 2'b00) return 24;
    return 32;
  endfunction

  function automatic logic exp_parity(input logic [7:0] d, input int nb, input logic even);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  // Decode one frame at the pins, starting at or before its start bit.
  task automatic rx_frame(input logic [7:0] exp, input int nw, input logic [7:0] w0,
                          input logic [7:0] w1, input bit meas, input bit scramble,
                          input string tag);
    int d = eff_div({div_hi, div_lo});
    logic [1:0] l = lcr_len;
    logic s = lcr_stop, pe = lcr_par_en, pv = lcr_par_even;
    int nb = 5 + int'(l);
    int st = stop_len(l, s);
    int guard = 0;
    int cnt = 0;
    while (txd !== 1'b0 && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R2 empty at frame start"}, int'(thr_empty), 1);
    wait_neg(8 * d);
    check({tag, " R4 start bit"}, int'(txd), 0);
    if (scramble) begin
      lcr_len = ~l; lcr_stop = ~s; lcr_par_en = ~pe; lcr_par_even = ~pv;
    end
    if (nw > 0) write_byte(w0);
    if (nw > 1) write_byte(w1);
    wait_neg(16 * d - 2 * nw);
    for (int i = 0; i < nb; i++) begin
      check($sformatf("%s R4 data bit %0d", tag, i), int'(txd), int'(exp[i]));
      wait_neg(16 * d);
    end
    if (pe) begin
      check({tag, " R5 parity"}, int'(txd), int'(exp_parity(exp, nb, pv)));
      wait_neg(16 * d);
    end
    check({tag, " R6 stop level"}, int'(txd), 1);
    if (meas) begin
      while (txd === 1'b1 && cnt < 100000) begin
        @(negedge clk);
        cnt++;
      end
      check({tag, " R3 R6 R9 stop length and gap"}, cnt, st * d + 1 - 8 * d);
    end else begin
      wait_neg(st * d - 8 * d + 2);
    end
    if (scramble) begin
      lcr_len = l; lcr_stop = s; lcr_par_en = pe; lcr_par_even = pv;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    wait_neg(5);
    check("R1 reset txd", int'(txd), 1);
    check("R1 reset empty", int'(thr_empty), 1);
    rst_n = 1'b1;
    wait_neg(3);
    check("R1 idle txd", int'(txd), 1);

    // table of framing vectors: each sends a byte, then its complement back to back
    for (int v = 0; v < 6; v++) begin
      logic [7:0] dat;
      dat = VEC[v][28:21];
      @(negedge clk);
      lcr_len = VEC[v][20:19]; lcr_stop = VEC[v][18];
      lcr_par_en = VEC[v][17]; lcr_par_even = VEC[v][16];
      {div_hi, div_lo} = VEC[v][15:0];
      write_byte(dat);
      check($sformatf("vec%0d R2 empty low after write", v), int'(thr_empty), 0);
      rx_frame(dat, 1, ~dat, 8'h00, 1'b1, 1'b0, $sformatf("vec%0d f1", v));
      rx_frame(~dat, 0, 8'h00, 8'h00, 1'b0, 1'b0, $sformatf("vec%0d f2", v));
      check($sformatf("vec%0d R1 idle after frames", v), int'(txd), 1);
    end

    // R7: control inputs changed mid-frame
    @(negedge clk);
    lcr_len = 2'b11; lcr_stop = 1'b1; lcr_par_en = 1'b1; lcr_par_even = 1'b1;
    {div_hi, div_lo} = 16'd2;
    write_byte(8'h6D);
    rx_frame(8'h6D, 0, 8'h00, 8'h00, 1'b0, 1'b1, "R7 scramble");
    check("R7 idle after scrambled frame", int'(txd), 1);

    // R8: two writes while busy, last one wins
    @(negedge clk);
    lcr_len = 2'b10; lcr_stop = 1'b0; lcr_par_en = 1'b0;
    {div_hi, div_lo} = 16'd1;
    write_byte(8'h11);
    rx_frame(8'h11, 2, 8'h22, 8'h33, 1'b1, 1'b0, "R8 first");
    rx_frame(8'h33, 0, 8'h00, 8'h00, 1'b0, 1'b0, "R8 overwrite");
    check("R8 nothing further pending", int'(thr_empty), 1);

    // R1: reset in the middle of a frame
    lcr_len = 2'b11;
    write_byte(8'h00);
    wait_neg(40);
    check("R1 line low mid-frame", int'(txd), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 txd after mid-frame reset", int'(txd), 1);
    check("R1 empty after mid-frame reset", int'(thr_empty), 1);
    rst_n = 1'b1;
    wait_neg(60);
    check("R1 no frame resumes after reset", int'(txd), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule